// File: doc/BRIEF.md
# Newton-Raphson Reciprocal of One Plus x

This block is a sequential fixed-point unit. It computes 1/(1+x) for an operand x in the open interval (0, 1). The operand is a signed 32-bit word with 31 fractional bits (Q0.31), and the result uses the same format.

The unit first forms a half denominator d = (1+x)/2, which lies in [1/2, 1). From d it builds a linear seed for 1/d in a format with two integer bits and 29 fractional bits (Q2.29). It then sharpens that seed with a fixed number of Newton-Raphson steps. Every product goes through one shared rounding doubling high multiplier. Every power-of-two scaling goes through one shared saturating left shifter. The refined 1/d is halved in value and converted back to Q0.31 by a final saturating doubling of the raw word.

A caller pulses `start` with the operand on `x_in`. A fixed number of cycles later it sees a one-cycle `done` pulse, with the answer on `recip`.

The controller has seven states:
- `ST_IDLE` waits for `start`.
- `ST_HALF` forms d.
- `ST_SEED` forms the seed.
- `ST_MUL_D`, `ST_MUL_X` and `ST_UPDATE` make up one refinement step.
- `ST_FINISH` produces the final scaling.

The transitions are:
- IDLE→HALF on `start`.
- HALF→SEED, SEED→MUL_D, MUL_D→MUL_X and MUL_X→UPDATE, each unconditionally.
- UPDATE→MUL_D while steps remain, and UPDATE→FINISH after the last step.
- FINISH→IDLE, raising `done`.

Top module: `nr_recip_fsm`

## Requirements
- R1: `start` is accepted only in the idle state, and `x_in` is captured on that same clock edge. A `start` during a computation has no effect on that result and begins no second computation.
- R2: The half denominator is d = (s + g) / 2, with the quotient truncated toward zero. Here s = x + 2147483647 is formed in 64 bits, and g = +1 when s >= 0, otherwise g = -1.
- R3: The seed is e0 = 1515870810 + M(d, -1010580540), where the sum wraps at 32 bits.
- R4: M(a, b) is the rounding doubling high product. Let p = a·b in 64 bits, and let n = 2^30 when p >= 0, otherwise n = 1 - 2^30. Then M = (p + n) / 2^31, truncated toward zero. The one exception is a = b = -2^31, which returns 2147483647.
- R5: ITERS refinement steps run, with a default of 3. Each step computes t = M(e, M(... )) as t = M(e, 2^29 - M(d, e)) and then sets e = e + S(t, 2). Both the subtraction and the addition wrap at 32 bits.
- R6: S(v, k) returns 2147483647 when v > 2^(31-k) - 1, returns -2^31 when v < -(2^(31-k) - 1), and returns v·2^k otherwise. The result is S(e, 1). For a very small x this saturates to 2147483647.
- R7: With `start` high in cycle c, `done` is high in cycle c + 4 + 3·ITERS and only in that cycle.
- R8: `recip` changes only in the cycle where `done` rises. It keeps its value until the next completed computation.
- R9: For every operand in (0, 1), the result has its sign bit clear.
- R10: During and after reset, and before any `start`, `done` is 0 and `recip` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| x_in | input | 32 | Operand x in Q0.31, expected in (0, 1) |
| done | output | 1 | One-cycle pulse marking a new result |
| recip | output | 32 | 1/(1+x) in Q0.31, held between results |

## Verification
The bench drives two instances from the same stimulus: one with the default three refinement steps and one with a single step. With a single step the seed error is still visible in the low bits, so an error in the seed constants, the half-sum rounding or the multiplier nudge shows up directly. It also exercises the loop exit at the smallest count, and the latency formula is checked at two points. Directed operands of 1, 2^30 and values near 2^31 reach the final saturation and the top of the half-sum range. Seeded random operands cover the interior of (0, 1).

// File: rtl/nr_recip_pkg.sv
package nr_recip_pkg;
    localparam int DW = 32;
    localparam int PW = 2 * DW;

    typedef logic signed [DW-1:0] word_t;

    localparam word_t WORD_MAX = 32'sh7fff_ffff;
    localparam word_t SEED_C0  = 32'sd1515870810;
    localparam word_t SEED_C1  = -32'sd1010580540;
    localparam word_t Q2_ONE   = 32'sd536870912;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALF,
        ST_SEED,
        ST_MUL_D,
        ST_MUL_X,
        ST_UPDATE,
        ST_FINISH
    } state_t;
endpackage

// File: rtl/nr_halfsum.sv
module nr_halfsum
    import nr_recip_pkg::*;
(
    input  word_t a,
    input  word_t b,
    output word_t y
);
    logic signed [PW-1:0] sum_w, adj_w, tz_w;

    always_comb begin
        sum_w = PW'(a) + PW'(b);
        adj_w = sum_w[PW-1] ? (sum_w - PW'(1)) : (sum_w + PW'(1));
        // divide by two, truncating toward zero
        tz_w  = adj_w[PW-1] ? (adj_w + PW'(1)) : adj_w;
        y     = DW'(tz_w >>> 1);
    end
endmodule

// File: rtl/nr_dhmul.sv
module nr_dhmul
    import nr_recip_pkg::*;
(
    input  word_t a,
    input  word_t b,
    output word_t y
);
    localparam logic signed [PW-1:0] NUDGE_POS = PW'(1) <<< (DW - 2);
    localparam logic signed [PW-1:0] NUDGE_NEG = PW'(1) - NUDGE_POS;
    localparam logic signed [PW-1:0] TZ_BIAS   = (PW'(1) <<< (DW - 1)) - PW'(1);

    logic signed [PW-1:0] a_w, b_w, prod_w, nudged_w, tz_w;
    logic                 both_min;

    always_comb begin
        a_w      = PW'(a);
        b_w      = PW'(b);
        prod_w   = a_w * b_w;
        nudged_w = prod_w + (prod_w[PW-1] ? NUDGE_NEG : NUDGE_POS);
        tz_w     = nudged_w + (nudged_w[PW-1] ? TZ_BIAS : PW'(0));
        both_min = (a == b) && (a == {1'b1, {(DW-1){1'b0}}});
        y        = both_min ? WORD_MAX : DW'(tz_w >>> (DW - 1));
    end
endmodule

// File: rtl/nr_satshl.sv
module nr_satshl
    import nr_recip_pkg::*;
#(
    parameter int SW = 2
) (
    input  word_t         v,
    input  logic [SW-1:0] sh,
    output word_t         y
);
    logic signed [PW-1:0] v_w, lim_w;

    always_comb begin
        v_w   = PW'(v);
        lim_w = (PW'(1) <<< (DW - 1 - int'(sh))) - PW'(1);
        if (v_w > lim_w)
            y = WORD_MAX;
        else if (v_w < -lim_w)
            y = {1'b1, {(DW-1){1'b0}}};
        else
            y = v <<< sh;
    end
endmodule

// File: rtl/nr_recip_fsm.sv
module nr_recip_fsm
    import nr_recip_pkg::*;
#(
    parameter int ITERS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] x_in,
    output logic          done,
    output logic [DW-1:0] recip
);
    localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [IW-1:0] LAST_STEP = IW'(ITERS - 1);

    state_t        state_q, state_d;
    word_t         x_q, d_q, est_q, prod_q, corr_q;
    logic [IW-1:0] step_q;
    logic          busy;

    word_t         hs_y, mul_a, mul_b, mul_y, sh_v, sh_y;
    logic [1:0]    sh_amt;

    assign busy = (state_q != ST_IDLE);

    nr_halfsum u_half (
        .a (x_q),
        .b (WORD_MAX),
        .y (hs_y)
    );

    nr_dhmul u_mul (
        .a (mul_a),
        .b (mul_b),
        .y (mul_y)
    );

    nr_satshl #(.SW(2)) u_shl (
        .v  (sh_v),
        .sh (sh_amt),
        .y  (sh_y)
    );

    // shared operand selection
    always_comb begin
        case (state_q)
            ST_SEED: begin
                mul_a = d_q;
                mul_b = SEED_C1;
            end
            ST_MUL_D: begin
                mul_a = d_q;
                mul_b = est_q;
            end
            default: begin
                mul_a = est_q;
                mul_b = Q2_ONE - prod_q;
            end
        endcase
        if (state_q == ST_UPDATE) begin
            sh_v   = corr_q;
            sh_amt = 2'd2;
        end else begin
            sh_v   = est_q;
            sh_amt = 2'd1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_HALF;
            ST_HALF:   state_d = ST_SEED;
            ST_SEED:   state_d = ST_MUL_D;
            ST_MUL_D:  state_d = ST_MUL_X;
            ST_MUL_X:  state_d = ST_UPDATE;
            ST_UPDATE: state_d = (step_q == LAST_STEP) ? ST_FINISH : ST_MUL_D;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            d_q    <= '0;
            est_q  <= '0;
            prod_q <= '0;
            corr_q <= '0;
            step_q <= '0;
            done   <= 1'b0;
            recip  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE:   if (start) x_q <= word_t'(x_in);
                ST_HALF:   d_q <= hs_y;
                ST_SEED: begin
                    est_q  <= SEED_C0 + mul_y;
                    step_q <= '0;
                end
                ST_MUL_D:  prod_q <= mul_y;
                ST_MUL_X:  corr_q <= mul_y;
                ST_UPDATE: begin
                    est_q  <= est_q + sh_y;
                    step_q <= step_q + IW'(1);
                end
                ST_FINISH: begin
                    recip <= sh_y;
                    done  <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nr_recip_chk.sv
module nr_recip_chk #(
    parameter int LAT = 13
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] recip
);
    localparam int CW = $clog2(LAT + 1) + 1;

    logic          run_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start && !busy) begin
            run_q <= 1'b1;
            cnt_q <= CW'(1);
        end else if (done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == CW'(LAT))); // R7
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_q); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(recip)); // R8
    AST_RESULT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !recip[31]); // R9
endmodule

bind nr_recip_fsm nr_recip_chk #(.LAT(4 + 3 * ITERS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .recip (recip)
);

// File: tb/test_nr_recip_fsm.sv
module test_nr_recip_fsm;
    localparam int LAT3 = 4 + 3 * 3;
    localparam int LAT1 = 4 + 3 * 1;
    localparam int MAXV = 32'sh7fff_ffff;
    localparam int MINV = 32'sh8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] x_in = '0;
    logic        done3, done1;
    logic [31:0] recip3, recip1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nr_recip_fsm i_nr_recip_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .done(done3), .recip(recip3)
    );

    nr_recip_fsm #(.ITERS(1)) i_nr_recip_fsm_one (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .done(done1), .recip(recip1)
    );

    function automatic int m_hi(int a, int b);
        longint p, n;
        if (a == MINV && b == MINV) return MAXV;
        p = longint'(a) * longint'(b);
        n = (p >= 0) ? (64'sd1 <<< 30) : (64'sd1 - (64'sd1 <<< 30));
        return int'((p + n) / (64'sd1 <<< 31));
    endfunction

    function automatic int s_shl(int v, int k);
        longint lim;
        lim = (64'sd1 <<< (31 - k)) - 64'sd1;
        if (longint'(v) > lim) return MAXV;
        if (longint'(v) < -lim) return MINV;
        return v <<< k;
    endfunction

    function automatic int ref_recip(int xv, int iters);
        longint s;
        int d, e, t;
        s = longint'(xv) + longint'(MAXV);
        s = s + ((s >= 0) ? 64'sd1 : -64'sd1);
        d = int'(s / 2);
        e = 1515870810 + m_hi(d, -1010580540);
        for (int i = 0; i < iters; i++) begin
            t = m_hi(e, 536870912 - m_hi(d, e));
            e = e + s_shl(t, 2);
        end
        return s_shl(e, 1);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] xv, input bit poke, input logic [31:0] xalt);
        int e3, e1, n3, n1, extra;
        e3 = ref_recip(int'(xv), 3);
        e1 = ref_recip(int'(xv), 1);
        n3 = 0; n1 = 0; extra = 0;
        @(negedge clk);
        start = 1'b1;
        x_in  = xv;
        @(negedge clk);
        start = 1'b0;
        x_in  = $urandom();
        for (int n = 1; n <= LAT3 + 4; n++) begin
            if (poke && n == 5) begin
                start = 1'b1;
                x_in  = xalt;
            end else begin
                start = 1'b0;
            end
            if (done3) begin
                if (n3 == 0) begin
                    n3 = n;
                    check(recip3 == e3, "R2 R3 R4 R5 R6 result", int'(recip3), e3);
                    check(!recip3[31], "R9 sign", int'(recip3), e3);
                end else extra++;
            end
            if (done1) begin
                if (n1 == 0) begin
                    n1 = n;
                    check(recip1 == e1, "R2 R3 R4 R5 single-step result", int'(recip1), e1);
                end else extra++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(n3 == LAT3, "R7 latency", n3, LAT3);
        check(n1 == LAT1, "R7 latency single-step", n1, LAT1);
        check(extra == 0, "R1 R7 no extra done", extra, 0);
        check(recip3 == e3, "R8 held", int'(recip3), e3);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rx;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(done3 == 1'b0, "R10 done in reset", done3, 0);
        check(recip3 == 32'd0, "R10 recip in reset", recip3, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done3 == 1'b0 && done1 == 1'b0, "R10 done idle", done3, 0);
        check(recip3 == 32'd0, "R10 recip idle", recip3, 0);

        // directed corners: R6 saturation on tiny x, top of range, midpoint
        run_op(32'd1, 1'b0, 32'd0);
        check(recip3 == 32'h7fff_ffff, "R6 saturate tiny x", recip3, MAXV);
        run_op(32'h7fff_ffff, 1'b0, 32'd0);
        run_op(32'h4000_0000, 1'b0, 32'd0);
        run_op(32'h7fff_fffe, 1'b0, 32'd0);
        run_op(32'h0000_ffff, 1'b0, 32'd0);
        run_op(32'h1000_0000, 1'b0, 32'd0);

        // R1: start while busy is ignored
        run_op(32'h2000_0000, 1'b1, 32'h0000_0003);
        run_op(32'h6000_0001, 1'b1, 32'h7fff_ffff);

        // R8: result held across idle cycles
        repeat (20) @(negedge clk);
        check(recip3 == ref_recip(32'h6000_0001, 3), "R8 held after idle",
              int'(recip3), ref_recip(32'h6000_0001, 3));

        for (int k = 0; k < 60; k++) begin
            rx = $urandom() & 32'h7fff_ffff;
            if (rx == 32'd0) rx = 32'd1;
            run_op(rx, (k % 7) == 3, $urandom() & 32'h7fff_ffff);
        end
        finish_run();
    end
endmodule